// File: doc/BRIEF.md
# Clock-Slave Audio Speed-Mode Detector

This block sits beside the serial port of an audio converter that receives its frame clock and master clock from outside. It works out which speed mode the incoming clocks imply (single, double or quad) and whether the master clock runs at the higher of the two ratios allowed in that mode. Other logic then uses these results to pick its decimation path.

The ratio between master clock and frame clock does not settle the mode alone, because 384x and 192x each belong to two modes. The block therefore counts master-clock cycles in each frame in the master-clock domain. It also measures each frame against a reference clock of known frequency in the reference domain. A result is reported only after two frames in a row agree. A stopped frame clock or a non-slave mode setting withdraws the result.

Top module: `slave_rate_detect`

## Requirements
- R1: After reset, and whenever `frame_valid` is 0, the outputs read `speed`=11, `fast_ratio`=0, `rate_unsup`=0.
- R2: A frame's master-clock count is taken as ratio 96, 192, 384 or 768 when it lies within ±TOL (2) of that value. Any other count is reported as unsupported, so 386 counts as 384 and 387 is rejected.
- R3: With ratio 384, a frame rate from 2 kHz to 50 kHz reports `speed`=00 (single) with `fast_ratio`=0. A rate from 86 kHz to 100 kHz reports `speed`=01 (double) with `fast_ratio`=1. Any other rate is unsupported.
- R4: With ratio 192, a frame rate above 50 kHz and up to 100 kHz reports `speed`=01 with `fast_ratio`=0. A rate from 172 kHz to 200 kHz reports `speed`=10 (quad) with `fast_ratio`=1. Any other rate is unsupported.
- R5: With ratio 768, a frame rate from 43 kHz to 50 kHz reports `speed`=00 with `fast_ratio`=1. Any other rate is unsupported.
- R6: Ratio 96 is reported as unsupported at every frame rate.
- R7: An unsupported result that has qualified reads `frame_valid`=1, `rate_unsup`=1, `speed`=11, `fast_ratio`=0.
- R8: After reset or a restart, the first rising frame edge only arms the measurement. `frame_valid` stays 0 after the second rising edge and can first rise on the classification at the third rising edge.
- R9: A frame whose classification differs from the one before it clears `frame_valid`. The next frame that agrees with it asserts `frame_valid` again with the new result.
- R10: While `mode_sel` is not 11, `frame_valid` is 0. Detection resumes when `mode_sel` returns to 11.
- R11: If no rising frame edge arrives for TIMEOUT_CYC reference cycles, `frame_valid` drops to 0. Detection restarts with the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock of frequency REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mclk | input | 1 | Master clock from the external clock source |
| lrck | input | 1 | Frame clock, one period per stereo sample |
| mode_sel | input | 2 | Mode pins; 11 selects slave detection |
| speed | output | 2 | 00 single, 01 double, 10 quad, 11 none or unsupported |
| fast_ratio | output | 1 | 1 when the higher ratio of the reported mode is in use |
| frame_valid | output | 1 | Result has held for two consecutive frames |
| rate_unsup | output | 1 | Qualified clock combination is not supported |

## Verification
The bench drives the two rate pairs that share a ratio. 384x at about 48 kHz and at 96 kHz must split into single and double speed. 192x at 96 kHz and at 192 kHz must split into double and quad. A detector that trusted the ratio alone would report the same mode for both rates of a pair. It also drives ratios just inside and just outside the ±2 tolerance, and fast ratios at rates outside their narrow windows. A wrong tolerance or missing window check would then show a supported mode where the block must report unsupported. The bench counts frame edges after reset and after a rate switch, which catches a block that asserts valid after one frame or keeps a stale result. Stopping the frame clock and leaving slave mode must both withdraw a result that was still being held.

// File: rtl/spd_pkg.sv
package spd_pkg;

   // Ratio classes found by the master-clock counter
   typedef enum logic [2:0] {
      RC_NONE = 3'd0,
      RC_X96  = 3'd1,
      RC_X192 = 3'd2,
      RC_X384 = 3'd3,
      RC_X768 = 3'd4
   } ratio_cls_e;

   // Reported speed codes
   typedef enum logic [1:0] {
      SPD_SINGLE = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10,
      SPD_NONE   = 2'b11
   } speed_e;

   typedef struct packed {
      speed_e code;
      logic   fast;
      logic   unsup;
   } spd_res_t;

   localparam int NUM_RATIOS = 4;

   // Nominal ratio for class index i (96, 192, 384, 768)
   function automatic int nominal_ratio(int idx);
      return 96 << idx;
   endfunction

   function automatic logic in_win(int v, int lo, int hi);
      return (v >= lo) && (v <= hi);
   endfunction

   localparam spd_res_t RES_IDLE = '{code: SPD_NONE, fast: 1'b0, unsup: 1'b0};
   localparam spd_res_t RES_BAD  = '{code: SPD_NONE, fast: 1'b0, unsup: 1'b1};

endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spd_sync needs at least two stages");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/spd_ratio_meter.sv
// Master-clock domain: counts mclk cycles between frame rising edges and
// classifies the count; toggles upd_tgl once per classified frame.
module spd_ratio_meter
   import spd_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int TOL         = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       mclk,
   input  logic       rst_n,
   input  logic       lrck,
   output ratio_cls_e cls,
   output logic       upd_tgl
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if ((1 << CNT_W) - 1 <= nominal_ratio(NUM_RATIOS-1) + TOL) begin : g_bad_width
      $error("CNT_W too narrow for the largest ratio");
   end
   if (TOL >= nominal_ratio(0) / 2) begin : g_bad_tol
      $error("TOL makes ratio windows overlap");
   end

   logic             lr_s, lr_d, rise;
   logic [CNT_W-1:0] cnt;
   ratio_cls_e       match;

   spd_sync #(.STAGES(SYNC_STAGES)) u_lr_sync (
      .clk(mclk), .rst_n(rst_n), .d(lrck), .q(lr_s)
   );

   assign rise = lr_s & ~lr_d;

   always_comb begin
      match = RC_NONE;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (in_win(int'(cnt), nominal_ratio(i) - TOL, nominal_ratio(i) + TOL))
            match = ratio_cls_e'(3'(i + 1));
      end
   end

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d    <= 1'b0;
         cnt     <= '0;
         cls     <= RC_NONE;
         upd_tgl <= 1'b0;
      end else begin
         lr_d <= lr_s;
         if (rise) begin
            cnt     <= CNT_W'(1);
            cls     <= match;
            upd_tgl <= ~upd_tgl;
         end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spd_period_meter.sv
// Reference domain: measures each frame period in reference cycles and
// flags a timeout when the frame clock stops.
module spd_period_meter #(
   parameter int TIMEOUT_CYC = 56250,
   parameter int PER_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lrck,
   output logic [PER_W-1:0] period,
   output logic             per_ok,
   output logic             tout_p
);
   if ((1 << PER_W) <= TIMEOUT_CYC) begin : g_bad_width
      $error("PER_W cannot hold TIMEOUT_CYC");
   end

   localparam logic [PER_W-1:0] TMO = PER_W'(TIMEOUT_CYC);

   logic             lr_s, lr_d, rise, armed;
   logic [PER_W-1:0] cnt;

   spd_sync #(.STAGES(SYNC_STAGES)) u_lr_sync (
      .clk(clk), .rst_n(rst_n), .d(lrck), .q(lr_s)
   );

   assign rise = lr_s & ~lr_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d   <= 1'b0;
         armed  <= 1'b0;
         cnt    <= '0;
         period <= '0;
         per_ok <= 1'b0;
         tout_p <= 1'b0;
      end else begin
         lr_d   <= lr_s;
         tout_p <= 1'b0;
         if (rise) begin
            armed <= 1'b1;
            cnt   <= PER_W'(1);
            if (armed) begin
               period <= cnt;
               per_ok <= 1'b1;
            end
         end else if (armed) begin
            if (cnt >= TMO) begin
               armed  <= 1'b0;
               per_ok <= 1'b0;
               tout_p <= 1'b1;
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spd_qualify.sv
// Reference domain: joins ratio class and frame period into a speed result
// and qualifies it over two consecutive frames.
module spd_qualify
   import spd_pkg::*;
#(
   parameter int REF_HZ = 100_000_000,
   parameter int PER_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slave,
   input  logic             eval,
   input  ratio_cls_e       rcls,
   input  logic [PER_W-1:0] period,
   input  logic             per_ok,
   input  logic             tout_p,
   output spd_res_t         res,
   output logic             valid
);
   // Period limits in reference cycles (longer period = slower rate)
   localparam int P_SGL_MAX  = REF_HZ / 2000;
   localparam int P_SGL_MIN  = REF_HZ / 50000;
   localparam int P_DBL_MIN  = REF_HZ / 100000;
   localparam int P_QD_MIN   = REF_HZ / 200000;
   localparam int P_SGLF_MAX = REF_HZ / 43000;
   localparam int P_DBLF_MAX = REF_HZ / 86000;
   localparam int P_QDF_MAX  = REF_HZ / 172000;

   if (P_QD_MIN < 8) begin : g_bad_ref
      $error("REF_HZ too low to separate the rate windows");
   end

   spd_res_t cur, prev;
   logic     have_prev;
   int       p;

   assign p = int'(period);

   always_comb begin
      cur = RES_BAD;
      case (rcls)
         RC_X768: begin
            if (in_win(p, P_SGL_MIN, P_SGLF_MAX))
               cur = '{code: SPD_SINGLE, fast: 1'b1, unsup: 1'b0};
         end
         RC_X384: begin
            if (in_win(p, P_SGL_MIN, P_SGL_MAX))
               cur = '{code: SPD_SINGLE, fast: 1'b0, unsup: 1'b0};
            else if (in_win(p, P_DBL_MIN, P_DBLF_MAX))
               cur = '{code: SPD_DOUBLE, fast: 1'b1, unsup: 1'b0};
         end
         RC_X192: begin
            if (in_win(p, P_DBL_MIN, P_SGL_MIN - 1))
               cur = '{code: SPD_DOUBLE, fast: 1'b0, unsup: 1'b0};
            else if (in_win(p, P_QD_MIN, P_QDF_MAX))
               cur = '{code: SPD_QUAD, fast: 1'b1, unsup: 1'b0};
         end
         default: cur = RES_BAD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev      <= RES_IDLE;
         have_prev <= 1'b0;
         res       <= RES_IDLE;
         valid     <= 1'b0;
      end else if (!slave || tout_p) begin
         have_prev <= 1'b0;
         res       <= RES_IDLE;
         valid     <= 1'b0;
      end else if (eval && per_ok) begin
         prev      <= cur;
         have_prev <= 1'b1;
         if (have_prev && (prev == cur)) begin
            res   <= cur;
            valid <= 1'b1;
         end else begin
            res   <= RES_IDLE;
            valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/slave_rate_detect.sv
module slave_rate_detect
   import spd_pkg::*;
#(
   parameter int REF_HZ      = 100_000_000,
   parameter int TIMEOUT_CYC = REF_HZ / 2000 + REF_HZ / 16000,
   parameter int TOL         = 2,
   parameter int MCNT_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic       ref_clk,
   input  logic       rst_n,
   input  logic       mclk,
   input  logic       lrck,
   input  logic [1:0] mode_sel,
   output logic [1:0] speed,
   output logic       fast_ratio,
   output logic       frame_valid,
   output logic       rate_unsup
);
   localparam int PER_W = $clog2(TIMEOUT_CYC + 1);

   if (TIMEOUT_CYC <= REF_HZ / 50000) begin : g_bad_tmo
      $error("TIMEOUT_CYC shorter than a 50 kHz frame");
   end
   if (PER_W > 31) begin : g_bad_per
      $error("TIMEOUT_CYC too large");
   end

   logic [1:0] mode_s;
   for (genvar b = 0; b < 2; b++) begin : g_mode_sync
      spd_sync #(.STAGES(SYNC_STAGES)) u_ms (
         .clk(ref_clk), .rst_n(rst_n), .d(mode_sel[b]), .q(mode_s[b])
      );
   end

   ratio_cls_e cls_m;
   logic       tgl_m, tgl_s, tgl_d, eval_stb;

   spd_ratio_meter #(
      .CNT_W(MCNT_W), .TOL(TOL), .SYNC_STAGES(SYNC_STAGES)
   ) u_ratio (
      .mclk(mclk), .rst_n(rst_n), .lrck(lrck), .cls(cls_m), .upd_tgl(tgl_m)
   );

   // Toggle crossing; cls_m is held from the toggle onwards, so it is
   // settled by the time the synchronized toggle is seen.
   spd_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(tgl_m), .q(tgl_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) tgl_d <= 1'b0;
      else        tgl_d <= tgl_s;
   end
   assign eval_stb = tgl_s ^ tgl_d;

   logic [PER_W-1:0] period;
   logic             per_ok, tout_p;

   spd_period_meter #(
      .TIMEOUT_CYC(TIMEOUT_CYC), .PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_period (
      .clk(ref_clk), .rst_n(rst_n), .lrck(lrck),
      .period(period), .per_ok(per_ok), .tout_p(tout_p)
   );

   spd_res_t res;

   spd_qualify #(.REF_HZ(REF_HZ), .PER_W(PER_W)) u_qual (
      .clk(ref_clk), .rst_n(rst_n), .slave(&mode_s), .eval(eval_stb),
      .rcls(cls_m), .period(period), .per_ok(per_ok), .tout_p(tout_p),
      .res(res), .valid(frame_valid)
   );

   assign speed      = res.code;
   assign fast_ratio = res.fast;
   assign rate_unsup = res.unsup;
endmodule

// File: rtl/slave_rate_detect_chk.sv
module slave_rate_detect_chk (
   input logic       ref_clk,
   input logic       rst_n,
   input logic [1:0] mode_sel,
   input logic [1:0] speed,
   input logic       fast_ratio,
   input logic       frame_valid,
   input logic       rate_unsup,
   input logic       eval,
   input logic       tout
);
   AST_IDLE_FIELDS: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !frame_valid |-> (speed == 2'b11) && !fast_ratio && !rate_unsup); // R1

   AST_UNSUP_FORM: assert property (@(posedge ref_clk) disable iff (!rst_n)
      frame_valid && rate_unsup |-> (speed == 2'b11) && !fast_ratio); // R7

   AST_SUP_CODE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      frame_valid && !rate_unsup |-> speed != 2'b11); // R3

   AST_RISE_ON_EVAL: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(frame_valid) |-> $past(eval)); // R8

   AST_HOLD_BETWEEN: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !eval && !tout && (mode_sel == 2'b11) && ($past(mode_sel) == 2'b11)
      && ($past(mode_sel, 2) == 2'b11) && ($past(mode_sel, 3) == 2'b11)
      |=> $stable(speed) && $stable(frame_valid)); // R9

   AST_MASTER_IDLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (mode_sel != 2'b11) && ($past(mode_sel) != 2'b11)
      && ($past(mode_sel, 2) != 2'b11) && ($past(mode_sel, 3) != 2'b11)
      |=> !frame_valid); // R10

   AST_TIMEOUT_DROP: assert property (@(posedge ref_clk) disable iff (!rst_n)
      tout |=> !frame_valid); // R11
endmodule

bind slave_rate_detect slave_rate_detect_chk u_chk (
   .ref_clk(ref_clk), .rst_n(rst_n), .mode_sel(mode_sel), .speed(speed),
   .fast_ratio(fast_ratio), .frame_valid(frame_valid), .rate_unsup(rate_unsup),
   .eval(eval_stb), .tout(tout_p)
);

// File: tb/slave_rate_detect_bench.sv
`timescale 1ns/1ps
module slave_rate_detect_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclk = 1'b0;
   logic       lrck = 1'b0;
   logic [1:0] mode_sel = 2'b11;
   logic [1:0] speed;
   logic       fast_ratio, frame_valid, rate_unsup;

   real mclk_half = 27.127;
   int  ratio_b   = 384;
   bit  lr_run    = 1'b0;
   int  lr_cnt    = 0;
   int  checks    = 0;
   int  errors    = 0;
   bit  finished  = 1'b0;

   // {valid, speed, fast, unsup}
   localparam logic [4:0] E_IDLE  = 5'b0_11_0_0;
   localparam logic [4:0] E_SGL   = 5'b1_00_0_0;
   localparam logic [4:0] E_SGLF  = 5'b1_00_1_0;
   localparam logic [4:0] E_DBL   = 5'b1_01_0_0;
   localparam logic [4:0] E_DBLF  = 5'b1_01_1_0;
   localparam logic [4:0] E_QDF   = 5'b1_10_1_0;
   localparam logic [4:0] E_UNSUP = 5'b1_11_0_1;

   slave_rate_detect #(.TIMEOUT_CYC(6000)) u_slave_rate_detect (
      .ref_clk(clk), .rst_n(rst_n), .mclk(mclk), .lrck(lrck),
      .mode_sel(mode_sel), .speed(speed), .fast_ratio(fast_ratio),
      .frame_valid(frame_valid), .rate_unsup(rate_unsup)
   );

   always #5 clk = ~clk;

   always begin
      #(mclk_half);
      mclk = ~mclk;
   end

   always @(negedge mclk) begin
      if (lr_run) begin
         if (lr_cnt >= (lrck ? ratio_b / 2 : ratio_b - ratio_b / 2) - 1) begin
            lr_cnt <= 0;
            lrck   <= ~lrck;
         end else begin
            lr_cnt <= lr_cnt + 1;
         end
      end
   end

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic chk(string tag, logic [4:0] exp);
      logic [4:0] act;
      act = {frame_valid, speed, fast_ratio, rate_unsup};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk_valid(string tag, logic exp);
      checks++;
      if (frame_valid !== exp) begin
         errors++;
         $display("FAIL %s valid actual=%b expected=%b", tag, frame_valid, exp);
      end
   endtask

   task automatic frames(int n);
      repeat (n) @(posedge lrck);
      repeat (100) @(negedge clk);
   endtask

   task automatic set_rate(int r, real h);
      if (lr_run) @(posedge lrck);
      ratio_b   = r;
      mclk_half = h;
   endtask

   task automatic run_case(string tag, int r, real h, logic [4:0] exp);
      set_rate(r, h);
      frames(4);
      chk(tag, exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (20) @(negedge clk);
      chk("R1 reset state", E_IDLE);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 idle after reset release", E_IDLE);
   endtask

   task automatic t_startup();
      set_rate(384, 27.127);
      lr_run = 1'b1;
      frames(2);
      chk_valid("R8 not valid after two edges", 1'b0);
      frames(1);
      chk("R8 R3 single 48k at 384x", E_SGL);
   endtask

   task automatic t_switch();
      set_rate(192, 27.127);
      frames(1);
      chk_valid("R9 mismatch clears valid", 1'b0);
      frames(1);
      chk("R9 R4 double 96k at 192x", E_DBL);
   endtask

   task automatic t_master();
      mode_sel = 2'b00;
      repeat (20) @(negedge clk);
      chk("R10 master mode idle", E_IDLE);
      frames(2);
      chk("R10 stays idle over frames", E_IDLE);
      mode_sel = 2'b11;
      frames(4);
      chk("R10 resumes in slave mode", E_UNSUP);
   endtask

   task automatic t_timeout();
      lr_run = 1'b0;
      repeat (7000) @(negedge clk);
      chk("R11 stopped frame clock", E_IDLE);
      lr_run = 1'b1;
      frames(4);
      chk("R11 recovery", E_UNSUP);
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      t_reset();
      t_startup();
      t_switch();
      run_case("R5 single fast 48k at 768x", 768, 13.563, E_SGLF);
      run_case("R3 double fast 96k at 384x", 384, 13.563, E_DBLF);
      run_case("R4 quad fast 192k at 192x", 192, 13.563, E_QDF);
      run_case("R6 R7 96x at 192k", 96, 27.127, E_UNSUP);
      run_case("R5 R7 768x at 32k", 768, 20.345, E_UNSUP);
      run_case("R3 R7 384x at 51k", 384, 25.53, E_UNSUP);
      run_case("R4 R7 192x at 45k", 192, 57.87, E_UNSUP);
      run_case("R2 ratio 386 within tolerance", 386, 27.127, E_SGL);
      run_case("R2 R7 ratio 387 outside tolerance", 387, 27.127, E_UNSUP);
      run_case("R2 ratio 500 rejected", 500, 27.127, E_UNSUP);
      t_master();
      t_timeout();
      finished = 1'b1;
      report();
   end
endmodule